// File: doc/BRIEF.md
# Interconnect Performance Monitor

This block counts activity inside an on-chip interconnect so that software can measure traffic and latency. It holds five 32-bit counters. Counter 0 counts clock cycles. Counters 1 to 4 each count one event chosen by software from a 256-wide vector of event strobes, which the interconnect drives. Software reaches all the state through a simple memory-mapped register port. Each counter has its own 4 KB page, and one global control word enables or halts all counting at once.

Each event identifier is 8 bits wide. The upper three bits name the source port. Sources 0 to 4 are slave-side ports and sources 5 to 7 are master-side ports. The lower five bits name the event code. A code outside the range allowed for its port type never counts. When a counter wraps from all ones to zero, its overflow flag is set, and that flag drives a level interrupt for the counter. Software presets a counter to program a sampling period and clears the flag by writing a one to it.

The register port uses a small access state machine with two states. `ACC_IDLE` is the idle state. `ACC_RESP` means read data is valid. A read request moves the machine from `ACC_IDLE` to `ACC_RESP`. In `ACC_RESP`, a further read request keeps the machine in `ACC_RESP`, and any other cycle returns it to `ACC_IDLE`. Writes take effect at the clock edge that accepts them and do not change the state.

Top module: `ic_perf_monitor`

## Requirements
- R1: After reset, the following all read zero and `irq_o` is 0: every counter value, counter enable, event selector and overflow flag, and the global enable. The global control word then reads 0x0000_2000.
- R2: Counter page i sits at address i*0x1000. Its registers are: event selector at 0x000 (bits 7:0), counter value at 0x004, counter enable at 0x008 (bit 0) and overflow flag at 0x00C (bit 0). The global control word is at 0x100 in page 0. Unmapped addresses read zero. Read data appears with `bus_rvalid` high on the cycle after the request.
- R3: Counter 0 adds one on every clock while both the global enable and its own enable are set. Its event selector always reads zero and ignores writes.
- R4: Counter k (1 to 4) adds one on each clock in which the event bit `evt_in[selector]` is high, provided both enables are set and the code is valid. Other event bits have no effect on it.
- R5: A selector is valid in two cases. Its source (bits 7:5) is 0 to 4 and its code (bits 4:0) is at most 0x14. Or its source is 5 to 7 and its code is at most 0x11. An invalid selector never counts.
- R6: When the global enable (bit 0 at 0x100) is clear, or the counter's own enable is clear, the counter value holds.
- R7: An increment from 0xFFFF_FFFF gives 0 and sets that counter's overflow flag.
- R8: Writing 1 to bit 0 of the overflow register clears the flag, and writing 0 leaves it unchanged. If a wrap and a clear occur in the same cycle, the flag stays set.
- R9: `irq_o[i]` equals the overflow flag of counter i.
- R10: If a software write to the counter value coincides with an increment, the written value is stored. No overflow is raised in that cycle.
- R11: Bits 15:11 of the global control word read back the number of event counters (4) and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| evt_in | input | 256 | Event strobes, indexed by event identifier |
| irq_o | output | 5 | Per-counter overflow interrupts |

## Verification
The bench pushes the selector range checks to their edges. It uses code 0x14 against 0x15 on slave sources and 0x11 against 0x12 on master sources, and it crosses the boundary between source 4 and source 5. A design that mixes up the two port ranges would count events it should reject. The bench also drives a wrap at the same edge as a software preset. A design with the wrong priority would keep the incremented value or raise a false interrupt. It checks that a write of zero to the overflow flag leaves it set, which exposes a plain read-write flag. Finally, it counts an exact number of cycles between enabling and halting, which catches an enable path that lags or leads by one cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int EVT_ID_W    = 8;
    localparam int SLV_SRC_CNT = 5;
    localparam logic [4:0] SLV_CODE_MAX = 5'h14;
    localparam logic [4:0] MST_CODE_MAX = 5'h11;

    localparam int OFF_SEL = 'h000;
    localparam int OFF_CNT = 'h004;
    localparam int OFF_CTL = 'h008;
    localparam int OFF_OVF = 'h00C;
    localparam int OFF_GLB = 'h100;

    localparam int NCNT_LSB = 11;
    localparam int NCNT_W   = 5;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    function automatic logic evt_id_valid(input logic [EVT_ID_W-1:0] id);
        logic [2:0] src;
        logic [4:0] code;
        src  = id[7:5];
        code = id[4:0];
        if (int'(src) < SLV_SRC_CNT)
            return code <= SLV_CODE_MAX;
        else
            return code <= MST_CODE_MAX;
    endfunction

endpackage

// File: rtl/pmu_event_filter.sv
module pmu_event_filter #(
    parameter bit IS_CYCLE = 1'b0,
    parameter int EVT_ID_W = pmu_pkg::EVT_ID_W
) (
    input  logic                    glb_en,
    input  logic                    cnt_en,
    input  logic [EVT_ID_W-1:0]     sel,
    input  logic [(1<<EVT_ID_W)-1:0] evt_in,
    output logic                    hit
);
    logic code_ok;
    logic level;

    always_comb begin
        code_ok = pmu_pkg::evt_id_valid(sel);
        level   = evt_in[sel];
        hit     = glb_en & cnt_en & (IS_CYCLE ? 1'b1 : (code_ok & level));
    end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter bit IS_CYCLE = 1'b0,
    parameter int CNT_W    = 32,
    parameter int EVT_ID_W = pmu_pkg::EVT_ID_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     glb_en,
    input  logic [(1<<EVT_ID_W)-1:0] evt_in,
    input  logic                     wr_sel,
    input  logic                     wr_cnt,
    input  logic                     wr_ctl,
    input  logic                     wr_ovf,
    input  logic [CNT_W-1:0]         wdata,
    output logic [EVT_ID_W-1:0]      sel_q,
    output logic [CNT_W-1:0]         cnt_q,
    output logic                     en_q,
    output logic                     ovf_q
);
    logic inc;
    logic wrap;

    pmu_event_filter #(
        .IS_CYCLE (IS_CYCLE),
        .EVT_ID_W (EVT_ID_W)
    ) u_filt (
        .glb_en (glb_en),
        .cnt_en (en_q),
        .sel    (sel_q),
        .evt_in (evt_in),
        .hit    (inc)
    );

    assign wrap = inc & (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            en_q  <= 1'b0;
        end else begin
            if (wr_sel && !IS_CYCLE) sel_q <= wdata[EVT_ID_W-1:0];
            if (wr_ctl)              en_q  <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wdata;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ovf_q <= 1'b0;
        else if (wrap && !wr_cnt)     ovf_q <= 1'b1;
        else if (wr_ovf && wdata[0])  ovf_q <= 1'b0;
    end

    assert_wrap_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (&cnt_q) && !wr_cnt) |=> (cnt_q == '0 && ovf_q));

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_cnt) |=> $stable(cnt_q));

    assert_master_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !inc);

    assert_sw_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wdata)));

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ovf && wdata[0] && !wrap) |=> !ovf_q);

endmodule

// File: rtl/pmu_regif.sv
module pmu_regif #(
    parameter int NUM_CNT    = 5,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 16,
    parameter int PAGE_SHIFT = 12,
    parameter int EVT_ID_W   = pmu_pkg::EVT_ID_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_en,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              glb_wbit,
    input  logic [NUM_CNT-1:0][EVT_ID_W-1:0]  sel_vals,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_vals,
    input  logic [NUM_CNT-1:0]                en_vals,
    input  logic [NUM_CNT-1:0]                ovf_vals,
    output logic [CNT_W-1:0]                  bus_rdata,
    output logic                              bus_rvalid,
    output logic                              glb_en,
    output logic [NUM_CNT-1:0]                wr_sel,
    output logic [NUM_CNT-1:0]                wr_cnt,
    output logic [NUM_CNT-1:0]                wr_ctl,
    output logic [NUM_CNT-1:0]                wr_ovf
);
    import pmu_pkg::*;

    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam logic [NCNT_W-1:0] NCNT_VAL = NCNT_W'(NUM_CNT - 1);

    acc_state_e state_q, state_d;
    logic [PAGE_W-1:0]     page;
    logic [PAGE_SHIFT-1:0] off;
    logic                  glb_hit;
    logic                  rd_req;
    logic                  wr_req;
    logic [CNT_W-1:0]      rd_mux;
    logic [CNT_W-1:0]      rdata_q;

    assign page    = bus_addr[ADDR_W-1:PAGE_SHIFT];
    assign off     = bus_addr[PAGE_SHIFT-1:0];
    assign glb_hit = (page == '0) && (off == PAGE_SHIFT'(OFF_GLB));
    assign rd_req  = bus_en & ~bus_we;
    assign wr_req  = bus_en & bus_we;

    always_comb begin
        for (int i = 0; i < NUM_CNT; i++) begin
            wr_sel[i] = wr_req && page == PAGE_W'(i) && off == PAGE_SHIFT'(OFF_SEL);
            wr_cnt[i] = wr_req && page == PAGE_W'(i) && off == PAGE_SHIFT'(OFF_CNT);
            wr_ctl[i] = wr_req && page == PAGE_W'(i) && off == PAGE_SHIFT'(OFF_CTL);
            wr_ovf[i] = wr_req && page == PAGE_W'(i) && off == PAGE_SHIFT'(OFF_OVF);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 glb_en <= 1'b0;
        else if (wr_req && glb_hit) glb_en <= glb_wbit;
    end

    always_comb begin
        rd_mux = '0;
        if (glb_hit) begin
            rd_mux[0] = glb_en;
            rd_mux[NCNT_LSB +: NCNT_W] = NCNT_VAL;
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (page == PAGE_W'(i)) begin
                if (off == PAGE_SHIFT'(OFF_SEL)) rd_mux[EVT_ID_W-1:0] = sel_vals[i];
                if (off == PAGE_SHIFT'(OFF_CNT)) rd_mux = cnt_vals[i];
                if (off == PAGE_SHIFT'(OFF_CTL)) rd_mux[0] = en_vals[i];
                if (off == PAGE_SHIFT'(OFF_OVF)) rd_mux[0] = ovf_vals[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_req) state_d = ACC_RESP;
            ACC_RESP: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_mux;
    end

    always_comb begin
        bus_rvalid = (state_q == ACC_RESP);
        bus_rdata  = rdata_q;
    end

    assert_read_responds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    assert_idle_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

endmodule

// File: rtl/ic_perf_monitor.sv
module ic_perf_monitor #(
    parameter int CNT_W       = 32,
    parameter int NUM_EVT_CNT = 4,
    parameter int ADDR_W      = 16,
    parameter int PAGE_SHIFT  = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_en,
    input  logic                               bus_we,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [CNT_W-1:0]                   bus_wdata,
    output logic [CNT_W-1:0]                   bus_rdata,
    output logic                               bus_rvalid,
    input  logic [(1<<pmu_pkg::EVT_ID_W)-1:0]  evt_in,
    output logic [NUM_EVT_CNT:0]               irq_o
);
    localparam int NUM_CNT  = NUM_EVT_CNT + 1;
    localparam int EVT_ID_W = pmu_pkg::EVT_ID_W;

    logic                             glb_en;
    logic [NUM_CNT-1:0]               wr_sel, wr_cnt, wr_ctl, wr_ovf;
    logic [NUM_CNT-1:0][EVT_ID_W-1:0] sel_vals;
    logic [NUM_CNT-1:0][CNT_W-1:0]    cnt_vals;
    logic [NUM_CNT-1:0]               en_vals;
    logic [NUM_CNT-1:0]               ovf_vals;

    pmu_regif #(
        .NUM_CNT    (NUM_CNT),
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .EVT_ID_W   (EVT_ID_W)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .glb_wbit   (bus_wdata[0]),
        .sel_vals   (sel_vals),
        .cnt_vals   (cnt_vals),
        .en_vals    (en_vals),
        .ovf_vals   (ovf_vals),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .glb_en     (glb_en),
        .wr_sel     (wr_sel),
        .wr_cnt     (wr_cnt),
        .wr_ctl     (wr_ctl),
        .wr_ovf     (wr_ovf)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        pmu_counter #(
            .IS_CYCLE (i == 0),
            .CNT_W    (CNT_W),
            .EVT_ID_W (EVT_ID_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .glb_en (glb_en),
            .evt_in (evt_in),
            .wr_sel (wr_sel[i]),
            .wr_cnt (wr_cnt[i]),
            .wr_ctl (wr_ctl[i]),
            .wr_ovf (wr_ovf[i]),
            .wdata  (bus_wdata),
            .sel_q  (sel_vals[i]),
            .cnt_q  (cnt_vals[i]),
            .en_q   (en_vals[i]),
            .ovf_q  (ovf_vals[i])
        );
    end

    assign irq_o = ovf_vals;

endmodule

// File: tb/sim_ic_perf_monitor.sv
module sim_ic_perf_monitor;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_en = 1'b0;
    logic         bus_we = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_rvalid;
    logic [255:0] evt_in = '0;
    logic [4:0]   irq_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    ic_perf_monitor u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .evt_in(evt_in), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  req;
    } row_t;

    localparam int NROW = 17;
    localparam row_t TBL [NROW] = '{
        '{1'b0, 16'h0100, 32'h0000_2000, 4'd1},  // R1 global word after reset
        '{1'b0, 16'h1004, 32'h0,         4'd1},  // R1 counter value zero
        '{1'b0, 16'h400C, 32'h0,         4'd1},  // R1 overflow zero
        '{1'b1, 16'h1000, 32'h0000_00A7, 4'd0},
        '{1'b0, 16'h1000, 32'h0000_00A7, 4'd2},  // R2 selector page 1
        '{1'b1, 16'h0000, 32'h0000_00FF, 4'd0},
        '{1'b0, 16'h0000, 32'h0,         4'd3},  // R3 cycle counter has no selector
        '{1'b1, 16'h4008, 32'h1,         4'd0},
        '{1'b0, 16'h4008, 32'h1,         4'd2},  // R2 enable bit page 4
        '{1'b1, 16'h4008, 32'h0,         4'd0},
        '{1'b0, 16'h4008, 32'h0,         4'd2},  // R2 enable cleared
        '{1'b1, 16'h0100, 32'hFFFF_FFFE, 4'd0},
        '{1'b0, 16'h0100, 32'h0000_2000, 4'd11}, // R11 count field read-only
        '{1'b0, 16'h0200, 32'h0,         4'd2},  // R2 unmapped offset
        '{1'b0, 16'h5004, 32'h0,         4'd2},  // R2 unmapped page
        '{1'b1, 16'h2004, 32'h1234_5678, 4'd0},
        '{1'b0, 16'h2004, 32'h1234_5678, 4'd2}   // R2 preset readback
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        if (!bus_rvalid) d = 32'hDEAD_BEEF;
        bus_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse_all(input int n);
        evt_in = '1;
        repeat (n) @(negedge clk);
        evt_in = '0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", {27'd0, irq_o}, 32'h0);   // R9 idle as well
        chk("R1 rvalid", {31'd0, bus_rvalid}, 32'h0);

        for (int i = 0; i < NROW; i++) begin
            if (TBL[i].we) wr(TBL[i].addr, TBL[i].data);
            else rd_chk($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].addr, TBL[i].data);
        end

        // R3 exact cycle count, R6 hold after halt
        wr(16'h0008, 1);
        wr(16'h0100, 1);
        repeat (9) @(negedge clk);
        wr(16'h0100, 0);
        rd_chk("R3 cycles", 16'h0004, 32'd10);
        rd_chk("R6 halted", 16'h0004, 32'd10);
        wr(16'h0008, 0);

        // R5 boundary codes, round one
        wr(16'h1000, 32'h14); wr(16'h2000, 32'h15);
        wr(16'h3000, 32'hB1); wr(16'h4000, 32'hB2);
        for (int k = 1; k <= 4; k++) begin
            wr(16'(k << 12) | 16'h0008, 1);
            wr(16'(k << 12) | 16'h0004, 0);
        end
        wr(16'h0100, 1);
        pulse_all(5);
        wr(16'h0100, 0);
        rd_chk("R5 slave 0x14", 16'h1004, 5);
        rd_chk("R5 slave 0x15", 16'h2004, 0);
        rd_chk("R5 master 0x11", 16'h3004, 5);
        rd_chk("R5 master 0x12", 16'h4004, 0);

        // R5 source boundary, R6 counter disable
        wr(16'h1000, 32'h94); wr(16'h2000, 32'hB4);
        wr(16'h3000, 32'hF1); wr(16'h4000, 32'hE0);
        wr(16'h4008, 0);
        for (int k = 1; k <= 4; k++) wr(16'(k << 12) | 16'h0004, 0);
        wr(16'h0100, 1);
        pulse_all(5);
        wr(16'h0100, 0);
        rd_chk("R5 src4 code 0x14", 16'h1004, 5);
        rd_chk("R5 src5 code 0x14", 16'h2004, 0);
        rd_chk("R5 src7 code 0x11", 16'h3004, 5);
        rd_chk("R6 counter disabled", 16'h4004, 0);

        // R4 only the selected bit counts
        wr(16'h1000, 32'h03);
        wr(16'h1004, 0);
        wr(16'h0100, 1);
        evt_in = '0; evt_in[4] = 1'b1;
        repeat (3) @(negedge clk);
        evt_in = '0; evt_in[3] = 1'b1;
        repeat (2) @(negedge clk);
        evt_in = '0;
        wr(16'h0100, 0);
        rd_chk("R4 selected bit", 16'h1004, 2);

        // R6 global enable off
        pulse_all(5);
        rd_chk("R6 global off", 16'h1004, 2);

        // R7 wrap, R9 irq, R8 clear
        wr(16'h1004, 32'hFFFF_FFFE);
        wr(16'h0100, 1);
        evt_in[3] = 1'b1;
        repeat (3) @(negedge clk);
        evt_in = '0;
        rd_chk("R7 wrapped value", 16'h1004, 1);
        rd_chk("R7 flag", 16'h100C, 1);
        chk("R9 irq set", {27'd0, irq_o}, 32'h2);
        wr(16'h100C, 0);
        rd_chk("R8 write zero keeps", 16'h100C, 1);
        wr(16'h100C, 1);
        rd_chk("R8 write one clears", 16'h100C, 0);
        chk("R9 irq cleared", {27'd0, irq_o}, 32'h0);

        // R10 preset beats wrap
        wr(16'h1004, 32'hFFFF_FFFF);
        evt_in[3] = 1'b1;
        wr(16'h1004, 5);
        evt_in = '0;
        rd_chk("R10 preset over wrap", 16'h1004, 5);
        rd_chk("R10 no overflow", 16'h100C, 0);
        evt_in[3] = 1'b1;
        wr(16'h1004, 32'h100);
        rd_chk("R10 preset over increment", 16'h1004, 32'h100);
        evt_in = '0;
        wr(16'h0100, 0);

        done = 1;
        finish_run();
    end

endmodule